// File: doc/BRIEF.md
# Transmit Frame Finisher (Pad and CRC-32 Append)

This block sits on the transmit path between a packet source and the line encoder. It takes a byte stream framed by start and end markers, and sends each frame out in its final form. A short frame is extended with zero bytes so that the frame, including its check sequence, reaches the 64-byte Ethernet minimum. A four-byte CRC-32 frame check sequence is then added after the last byte. The input and the output both use a valid/ready handshake, so backpressure from the output reaches the source. The block inserts no register stage in the payload path.

Each packet runs in one of three treatments. The block picks the treatment on the first byte of the packet, from a per-packet raw flag and two static configuration bits. The raw flag wins over both configuration bits and sends the packet untouched. The CRC-disable bit also turns padding off. The pad-disable bit only has an effect when the CRC-disable bit is clear. The treatment is held until the packet ends, so changes to these inputs in the middle of a packet have no effect.

Top module: `tx_fin_top`

## Requirements
- R1: With raw, CRC-disable and pad-disable all low at the first byte, a frame of fewer than 60 input bytes is followed by zero-valued bytes up to 60 bytes, then by 4 check bytes, for 64 output bytes in total. A one-byte frame is included.
- R2: With the same settings, a frame of 60 or more input bytes gets no padding and is followed directly by the 4 check bytes.
- R3: The check value is CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF. It is computed over every output byte before it, padding included, and complemented. Its least significant byte is sent first. The nine bytes "123456789" give the check bytes 26 39 F4 CB.
- R4: With CRC-disable high at the first byte, the frame goes out exactly as supplied, with no padding and no check bytes.
- R5: While CRC-disable is high, the pad-disable bit has no effect: with both high, the output is the same as with CRC-disable alone.
- R6: With pad-disable high and CRC-disable low, a short frame is not padded but still gets its 4 check bytes.
- R7: The raw flag is sampled only on the first byte. When it is high there, the frame goes out exactly as supplied, whatever the two configuration bits are. When it is high only on later bytes, it is ignored.
- R8: Both configuration bits are sampled only on the first byte of a frame. Changing them in the middle of the frame does not alter how that frame is treated.
- R9: A byte moves when valid and ready are both high. While padding or check bytes are sent, input ready is low. A stalled generated byte stays valid and unchanged until it is accepted.
- R10: While reset is active, output valid and input ready are both low. After reset, with no input, output valid is low and input ready follows output ready.
- R11: Each input byte appears at the output in the same cycle as it is offered. The start marker is on the first output byte and the end marker on the last output byte of the frame (the last check byte, or the last input byte when nothing is appended).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can accept the input byte |
| s_data | input | 8 | Input byte |
| s_sop | input | 1 | Input byte is the first of a frame |
| s_eop | input | 1 | Input byte is the last of a frame |
| s_raw | input | 1 | Send this frame unmodified (sampled at first byte) |
| cfg_nocrc | input | 1 | Append no check bytes and no padding |
| cfg_nopad | input | 1 | Do not pad short frames (no effect while cfg_nocrc is high) |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output byte |
| m_sop | output | 1 | Output byte is the first of a frame |
| m_eop | output | 1 | Output byte is the last of a frame |

## Verification
Payload bytes pass through with zero cycles of latency. The bench therefore drives each input shortly after the falling edge and reads the output one time unit later, in the same cycle, to compare it with the byte offered there. Padding and check bytes follow on the cycles after the last payload byte is accepted, one per accepted output cycle, with no gap. The bench collects them in handshake order and does not predict their cycle numbers, so output stalls do not change the expected byte sequence. The cycle after a stalled generated byte is compared with the held value. Reset release takes two clock edges through the synchronizer, and the bench waits past those edges before its first frame.

// File: rtl/tx_fin_pkg.sv
package tx_fin_pkg;

  localparam int FCS_BYTES = 4;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    MODE_PASS     = 2'd0,
    MODE_CRC_ONLY = 2'd1,
    MODE_FULL     = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } state_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'd0, d};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/tx_fin_rst_sync.sv
module tx_fin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tx_fin_mode.sv
module tx_fin_mode
  import tx_fin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  s_sop,
  input  logic  s_raw,
  input  logic  cfg_nocrc,
  input  logic  cfg_nopad,
  output mode_e mode_eff,
  output mode_e mode_q
);
  mode_e mode_d;

  // Priority: raw flag, then CRC disable (which also kills padding), then pad disable.
  always_comb begin
    if (s_raw)          mode_d = MODE_PASS;
    else if (cfg_nocrc) mode_d = MODE_PASS;
    else if (cfg_nopad) mode_d = MODE_CRC_ONLY;
    else                mode_d = MODE_FULL;
  end

  always_comb begin
    mode_eff = s_sop ? mode_d : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= MODE_PASS;
    else if (load) mode_q <= mode_d;
  end
endmodule

// File: rtl/tx_fin_crc.sv
module tx_fin_crc
  import tx_fin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd_en,
  input  logic        restart,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] crc_q;
  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_step(restart ? CRC_SEED : crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (upd_en) crc_q <= crc_d;
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/tx_fin_seq.sv
module tx_fin_seq
  import tx_fin_pkg::*;
#(
  parameter int MIN_PAYLOAD = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_sop,
  input  logic        s_eop,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  output logic        m_sop,
  output logic        m_eop,
  input  mode_e       mode_eff,
  input  mode_e       mode_q,
  input  logic [31:0] fcs,
  output logic        sop_load,
  output logic        crc_en,
  output logic        crc_restart,
  output logic [7:0]  crc_din
);
  localparam int CW = $clog2(MIN_PAYLOAD + 1);
  localparam int IW = $clog2(FCS_BYTES);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_PAYLOAD);
  localparam logic [IW-1:0] LAST_I = IW'(FCS_BYTES - 1);

  state_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_base, cnt_inc, cnt_pad;
  logic          out_fire;

  always_comb begin
    cnt_base = s_sop ? '0 : cnt_q;
    cnt_inc  = (cnt_base == MIN_C) ? MIN_C : cnt_base + 1'b1;
    cnt_pad  = cnt_q + 1'b1;
  end

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    s_ready     = 1'b0;
    m_valid     = 1'b0;
    m_data      = 8'h00;
    m_sop       = 1'b0;
    m_eop       = 1'b0;
    crc_en      = 1'b0;
    crc_restart = 1'b0;
    sop_load    = 1'b0;
    case (st_q)
      ST_DATA: begin
        s_ready = m_ready & rst_n;
        m_valid = s_valid & rst_n;
        m_data  = s_data;
        m_sop   = s_sop;
        m_eop   = s_eop && (mode_eff == MODE_PASS);
        if (s_valid && m_ready && rst_n) begin
          sop_load    = s_sop;
          cnt_d       = cnt_inc;
          crc_en      = (mode_eff != MODE_PASS);
          crc_restart = s_sop;
          if (s_eop) begin
            if (mode_eff == MODE_FULL && cnt_inc < MIN_C) st_d = ST_PAD;
            else if (mode_eff != MODE_PASS)               st_d = ST_FCS;
          end
        end
      end
      ST_PAD: begin
        m_valid = 1'b1;
        m_data  = 8'h00;
        if (m_ready) begin
          crc_en = 1'b1;
          cnt_d  = cnt_pad;
          if (cnt_pad == MIN_C) st_d = ST_FCS;
        end
      end
      ST_FCS: begin
        m_valid = 1'b1;
        m_data  = fcs[{idx_q, 3'b000} +: 8];
        m_eop   = (idx_q == LAST_I);
        if (m_ready) begin
          if (idx_q == LAST_I) begin
            idx_d = '0;
            st_d  = ST_DATA;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_DATA;
    endcase
  end

  assign crc_din  = m_data;
  assign out_fire = m_valid & m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_DATA;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  // Frame length tracker used only by the checks below.
  logic [15:0] olen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) olen_q <= '0;
    else if (out_fire) olen_q <= m_sop ? 16'd1 : ((olen_q == 16'hFFFF) ? olen_q : olen_q + 16'd1);
  end

  assert_min_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && m_eop && st_q == ST_FCS && mode_q == MODE_FULL)
      |-> (32'(olen_q) + 32'd1 >= 32'(MIN_PAYLOAD + FCS_BYTES)));

  assert_pad_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAD) |-> (cnt_q < MIN_C));

  assert_pass_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DATA) |-> (mode_q != MODE_PASS));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DATA && m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

endmodule

// File: rtl/tx_fin_top.sv
module tx_fin_top
  import tx_fin_pkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sop,
  input  logic       s_eop,
  input  logic       s_raw,
  input  logic       cfg_nocrc,
  input  logic       cfg_nopad,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_sop,
  output logic       m_eop
);
  localparam int MIN_PAYLOAD = MIN_FRAME - FCS_BYTES;

  logic        rst_n;
  logic        sop_load;
  logic        crc_en;
  logic        crc_restart;
  logic [7:0]  crc_din;
  logic [31:0] fcs;
  mode_e       mode_eff;
  mode_e       mode_q;

  tx_fin_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  tx_fin_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sop_load),
    .s_sop     (s_sop),
    .s_raw     (s_raw),
    .cfg_nocrc (cfg_nocrc),
    .cfg_nopad (cfg_nopad),
    .mode_eff  (mode_eff),
    .mode_q    (mode_q)
  );

  tx_fin_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (crc_en),
    .restart (crc_restart),
    .din     (crc_din),
    .fcs     (fcs)
  );

  tx_fin_seq #(.MIN_PAYLOAD(MIN_PAYLOAD)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_data      (s_data),
    .s_sop       (s_sop),
    .s_eop       (s_eop),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_data      (m_data),
    .m_sop       (m_sop),
    .m_eop       (m_eop),
    .mode_eff    (mode_eff),
    .mode_q      (mode_q),
    .fcs         (fcs),
    .sop_load    (sop_load),
    .crc_en      (crc_en),
    .crc_restart (crc_restart),
    .crc_din     (crc_din)
  );
endmodule

// File: tb/tx_fin_top_test.sv
module tx_fin_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // [13:6] length, [5] raw, [4] nocrc, [3] nopad, [2] raw on later bytes, [1] flip cfg after first byte, [0] output stalls
  localparam logic [13:0] VEC [0:NVEC-1] = '{
    {8'd10, 6'b000000},  // R1 short frame padded
    {8'd60, 6'b000000},  // R2 exact minimum payload
    {8'd75, 6'b000001},  // R2 long frame with stalls
    {8'd10, 6'b010000},  // R4 crc disable
    {8'd10, 6'b011000},  // R5 both disables
    {8'd10, 6'b001001},  // R6 pad disable only, stalls
    {8'd10, 6'b100000},  // R7 raw
    {8'd20, 6'b111000},  // R7 raw with both cfg bits
    {8'd10, 6'b000100},  // R7 raw only on later bytes
    {8'd12, 6'b000011},  // R8 cfg flips to disables mid-frame
    {8'd1,  6'b000000},  // R1 single byte
    {8'd59, 6'b000001},  // R1 one short of minimum
    {8'd12, 6'b010010}   // R8 crc disable dropped mid-frame
  };

  logic       clk = 1'b0;
  logic       arst_n;
  logic       s_valid, s_ready, s_sop, s_eop, s_raw;
  logic [7:0] s_data;
  logic       cfg_nocrc, cfg_nopad;
  logic       m_valid, m_ready, m_sop, m_eop;
  logic [7:0] m_data;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_fin_top uut (
    .clk(clk), .arst_n(arst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
    .s_raw(s_raw), .cfg_nocrc(cfg_nocrc), .cfg_nopad(cfg_nopad),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 10, 11: return "R1";
      1, 2:      return "R2";
      3:         return "R4";
      4:         return "R5";
      5:         return "R6";
      6, 7, 8:   return "R7";
      default:   return "R8";
    endcase
  endfunction

  function automatic logic [31:0] ref_crc(input logic [7:0] buf_in [0:127], input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, buf_in[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  logic [7:0] got [0:127];
  int         got_n;

  task automatic run_pkt(input int v, input int len, input bit raw, input bit nocrc, input bit nopad,
                         input bit rawmid, input bit flip, input bit stall, input bit ascii, input string tag);
    logic [7:0] pay [0:127];
    logic [7:0] expb [0:127];
    int exp_n, in_idx, cyc, hold_bad, ready_bad, mark_bad, lat_bad, byte_bad;
    bit done, pend, pass_m, full_m;
    logic [7:0] prev_d;
    logic [31:0] c;
    for (int i = 0; i < 128; i++) begin
      pay[i]  = ascii ? 8'(8'h31 + i) : 8'((i * 37 + v * 11 + 5) & 255);
      expb[i] = 8'h00;
    end
    pass_m = raw | nocrc;
    full_m = !pass_m && !nopad;
    exp_n = len;
    for (int i = 0; i < len; i++) expb[i] = pay[i];
    if (full_m) while (exp_n < 60) begin expb[exp_n] = 8'h00; exp_n++; end
    if (!pass_m) begin
      c = ref_crc(expb, exp_n);
      for (int k = 0; k < 4; k++) begin expb[exp_n] = c[8*k +: 8]; exp_n++; end
    end
    in_idx = 0; cyc = 0; got_n = 0; done = 0; pend = 0; prev_d = 8'h00;
    hold_bad = 0; ready_bad = 0; mark_bad = 0; lat_bad = 0;
    while (!done && cyc < 600) begin
      @(negedge clk);
      cyc++;
      if (pend && !(m_valid && m_data == prev_d)) hold_bad++;
      m_ready   = stall ? ((cyc % 3) != 0) : 1'b1;
      s_valid   = (in_idx < len);
      s_data    = pay[in_idx];
      s_sop     = (in_idx == 0);
      s_eop     = (in_idx == len - 1);
      s_raw     = (in_idx == 0) ? raw : rawmid;
      cfg_nocrc = (flip && in_idx > 0) ? ~nocrc : nocrc;
      cfg_nopad = (flip && in_idx > 0) ? ~nopad : nopad;
      #1;
      if (s_valid && !(m_valid && m_data == s_data)) lat_bad++;
      if (got_n >= len && m_valid && s_ready) ready_bad++;
      if (m_valid && m_ready) begin
        if (m_sop != (got_n == 0)) mark_bad++;
        got[got_n] = m_data;
        if (m_eop) done = 1;
        got_n++;
      end
      pend   = m_valid && !m_ready;
      prev_d = m_data;
      if (s_valid && s_ready) in_idx++;
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_raw = 1'b0;
    byte_bad = 0;
    for (int i = 0; i < got_n && i < exp_n; i++) if (got[i] !== expb[i]) byte_bad++;
    check({tag, " frame length"}, got_n == exp_n, got_n, exp_n);
    check({tag, " frame bytes (R3 check value)"}, byte_bad == 0, byte_bad, 0);
    check("R11 markers", done && mark_bad == 0, mark_bad, 0);
    check("R11 same-cycle payload", lat_bad == 0, lat_bad, 0);
    check("R9 stall hold", hold_bad == 0, hold_bad, 0);
    check("R9 ready low while appending", ready_bad == 0, ready_bad, 0);
  endtask

  initial begin
    arst_n = 1'b0;
    s_valid = 1'b1; s_data = 8'h00; s_sop = 1'b1; s_eop = 1'b0; s_raw = 1'b0;
    cfg_nocrc = 1'b0; cfg_nopad = 1'b0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R10 valid low in reset", m_valid == 1'b0, m_valid, 0);
    check("R10 ready low in reset", s_ready == 1'b0, s_ready, 0);
    s_valid = 1'b0; s_sop = 1'b0;
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R10 idle valid", m_valid == 1'b0, m_valid, 0);
    check("R10 idle ready", s_ready == 1'b1, s_ready, 1);
    m_ready = 1'b0;
    #1;
    check("R10 ready follows output", s_ready == 1'b0, s_ready, 0);
    m_ready = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      run_pkt(v, int'(VEC[v][13:6]), VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0, vtag(v));
    end

    // R3 known answer: "123456789" with padding off
    run_pkt(20, 9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    check("R3 known check bytes", {got[12], got[11], got[10], got[9]} == 32'hCBF43926,
          int'({got[12], got[11], got[10], got[9]}), int'(32'hCBF43926));

    // R5 with stalls and back-to-back frames
    run_pkt(21, 30, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    run_pkt(22, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule